// File: doc/BRIEF.md
# Guarded Clock Divider Control Register

This block is an 8-bit control register that sets how much the master clock is divided before synchronous logic uses it. It does not gate any clock. It produces a clock-enable pulse that lasts one master cycle and recurs every 2^k master cycles. Downstream flops qualify their updates with this pulse.

A stray write must not be able to change the divider. So the divider code is protected by a short timed unlock. Software first writes the unlock byte `0x80`, which opens a window of four master cycles. A second write with the top bit clear then stores a new code and closes the window. A strap input picks the code loaded at reset, either divide-by-1 or divide-by-8. A new factor does not cut short the enable period already running. It takes effect at the next enable pulse.

There is no data stream at this block's edge. The register port is a plain write strobe with a combinational read-back, so no valid/ready handshake and no back-pressure apply.

Top module: `clkdiv_guard_reg`

## Requirements
- R1: Read data shows the unlock flag in bit 7. Bits 6:4 always read zero. Bits 3:0 hold the stored divider code exactly as written, including codes 9 to 15.
- R2: The unlock flag is set only by a write whose data is exactly `0x80` (bit 7 one, bits 6:0 zero). Any other write with bit 7 set leaves a closed window closed.
- R3: Once set, the unlock flag reads one for exactly four master cycles after the unlocking write, then clears by itself.
- R4: While the window is open, a write with bit 7 set has no effect. This covers a repeated `0x80`, which neither restarts the four-cycle timeout nor clears the flag. It also covers any other value with bit 7 set, which leaves the stored code unchanged.
- R5: A write with bit 7 clear, made while the flag reads one, stores bits 3:0 as the new code and clears the flag in the next cycle. Writes with bit 7 clear while the window is closed, including after a timeout, leave the code unchanged.
- R6: After reset the code is 0 (divide by 1) when `strap_div8` is low and 3 (divide by 8) when it is high. Any code can be stored afterwards, whichever strap value was used.
- R7: For stored codes 0 to 8 the enable pulse is one cycle wide and recurs every 2^code master cycles. With code 0 it is high in every cycle.
- R8: Codes 9 to 15 are stored and read back, but the enable period stays at the last factor given by a valid code.
- R9: A new factor starts only after the next enable pulse. The period running when the code is written keeps its old length, so no period is ever shortened or merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| strap_div8 | input | 1 | Reset-default select: high loads divide-by-8 |
| wr_en | input | 1 | Register write strobe, one write per cycle it is high |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read-back: {flag, 3'b000, code} |
| clk_en | output | 1 | Divided clock-enable pulse |

## Verification
The hardest state to reach from the ports is a code change that lands in the middle of a long enable period. To show R9, the period must be seen to finish at its old length and only then switch. The stimulus sets the factor to 256 and waits for a pulse. Ten cycles later it opens the window and writes code 0. A bench-side gap monitor must then measure one gap of 256 followed by a gap of 1. A second tricky point is replaying the unlock byte inside an open window. The bench steps writes cycle by cycle, so the flag is shown to drop exactly four cycles after the first unlock, not after the replay.

// File: rtl/clkdiv_guard_pkg.sv
package clkdiv_guard_pkg;
  localparam int REG_W      = 8;   // register width
  localparam int CODE_W     = 4;   // divider select field width
  localparam int LOG_MAX    = 8;   // largest valid code (factor 2^LOG_MAX)
  localparam int WINDOW_CYC = 4;   // unlock window length in cycles
  localparam int STRAP_CODE = 3;   // code loaded when the strap is high

  typedef logic [CODE_W-1:0] code_t;

  function automatic logic code_is_valid(input code_t c);
    return (int'(c) <= LOG_MAX);
  endfunction
endpackage

// File: rtl/clkdiv_unlock_window.sv
module clkdiv_unlock_window #(
  parameter int WIN = clkdiv_guard_pkg::WINDOW_CYC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,    // exact unlock byte written
  input  logic commit,      // guarded code write accepted
  output logic open_q
);
  localparam int TW = (WIN > 1) ? $clog2(WIN) : 1;

  logic [TW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      left_q <= '0;
    end else if (!open_q) begin
      if (open_req) begin
        open_q <= 1'b1;
        left_q <= TW'(WIN - 1);
      end
    end else if (commit || left_q == '0) begin
      open_q <= 1'b0;
    end else begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/clkdiv_code_reg.sv
module clkdiv_code_reg
  import clkdiv_guard_pkg::*;
#(
  parameter int CW      = CODE_W,
  parameter int LMAX    = LOG_MAX,
  parameter int SLOW_CD = STRAP_CODE,
  localparam int LW     = $clog2(LMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap,
  input  logic          load,
  input  logic [CW-1:0] code_in,
  output logic [CW-1:0] code_q,
  output logic [LW-1:0] log_q      // last valid factor exponent
);
  logic [CW-1:0] boot_code;
  logic          in_ok;

  assign boot_code = strap ? CW'(SLOW_CD) : '0;
  assign in_ok     = (int'(code_in) <= LMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= boot_code;
      log_q  <= LW'(boot_code);
    end else if (load) begin
      code_q <= code_in;
      if (in_ok) log_q <= LW'(code_in);
    end
  end
endmodule

// File: rtl/clkdiv_tick_gen.sv
module clkdiv_tick_gen #(
  parameter int LMAX = clkdiv_guard_pkg::LOG_MAX,
  localparam int LW  = $clog2(LMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] log_in,
  output logic          tick
);
  logic [LMAX-1:0] cnt_q;
  logic [LMAX-1:0] reload;

  // reload value 2^log_in - 1 built bit by bit
  for (genvar g = 0; g < LMAX; g++) begin : g_mask
    assign reload[g] = (int'(log_in) > g);
  end

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= reload;   // new factor only at a pulse boundary
    else           cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/clkdiv_guard_reg.sv
module clkdiv_guard_reg
  import clkdiv_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_div8,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             clk_en
);
  localparam int LW  = $clog2(LOG_MAX + 1);
  localparam int TOP = REG_W - 1;
  localparam int PAD = REG_W - CODE_W - 1;

  logic        win_open;
  logic        is_unlock;
  logic        is_commit;
  code_t       code_q;
  logic [LW-1:0] log_q;

  assign is_unlock = wr_en && wr_data[TOP] && (wr_data[TOP-1:0] == '0);
  assign is_commit = wr_en && !wr_data[TOP] && win_open;

  clkdiv_unlock_window #(.WIN(WINDOW_CYC)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .open_req(is_unlock),
    .commit  (is_commit),
    .open_q  (win_open)
  );

  clkdiv_code_reg #(.CW(CODE_W), .LMAX(LOG_MAX), .SLOW_CD(STRAP_CODE)) u_code (
    .clk    (clk),
    .rst_n  (rst_n),
    .strap  (strap_div8),
    .load   (is_commit),
    .code_in(wr_data[CODE_W-1:0]),
    .code_q (code_q),
    .log_q  (log_q)
  );

  clkdiv_tick_gen #(.LMAX(LOG_MAX)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .log_in(log_q),
    .tick  (clk_en)
  );

  assign rd_data = {win_open, {PAD{1'b0}}, code_q};
endmodule

// File: rtl/clkdiv_guard_reg_chk.sv
module clkdiv_guard_reg_chk #(
  parameter int WIN = clkdiv_guard_pkg::WINDOW_CYC
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       clk_en
);
  logic [7:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          hi_cnt <= '0;
    else if (rd_data[7]) hi_cnt <= hi_cnt + 1'b1;
    else                 hi_cnt <= '0;
  end

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:4] == 3'b000);

  assert_unlock_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[7]) |-> $past(wr_en && wr_data == 8'h80));

  assert_window_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] |-> (int'(hi_cnt) < WIN));

  assert_rewrite_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && int'(hi_cnt) < WIN - 1 && wr_en && wr_data[7]) |=> rd_data[7]);

  assert_code_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3:0] != $past(rd_data[3:0])) |-> $past(wr_en && !wr_data[7] && rd_data[7]));

  assert_commit_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[7] && rd_data[7]) |=> !rd_data[7]);

  assert_tick_known_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(clk_en));
endmodule

bind clkdiv_guard_reg clkdiv_guard_reg_chk #(.WIN(clkdiv_guard_pkg::WINDOW_CYC)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .wr_data(wr_data),
  .rd_data(rd_data),
  .clk_en (clk_en)
);

// File: tb/clkdiv_guard_reg_tb.sv
`timescale 1ns/1ps
module clkdiv_guard_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_div8 = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       clk_en;

  int checks = 0;
  int errors = 0;
  int gap_cnt = 0;
  int last_gap = 0;
  int pulses = 0;

  always #5 clk = ~clk;

  clkdiv_guard_reg u_dut (
    .clk(clk), .rst_n(rst_n), .strap_div8(strap_div8),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .clk_en(clk_en)
  );

  // bench-side gap monitor: cycles between enable pulses
  always @(negedge clk) begin
    if (!rst_n) begin
      gap_cnt = 0;
    end else if (clk_en) begin
      last_gap = gap_cnt;
      gap_cnt = 1;
      pulses = pulses + 1;
    end else begin
      gap_cnt = gap_cnt + 1;
    end
  end

  // stimulus table: code written, expected period afterwards
  localparam int NV = 9;
  localparam logic [3:0] V_CODE [NV] = '{4'd3, 4'd8, 4'd2, 4'd9, 4'd15, 4'd0, 4'd5, 4'd1, 4'd12};
  localparam int         V_GAP  [NV] = '{8, 256, 4, 4, 4, 1, 32, 2, 2};

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic wait_pulses(input int n);
    int target;
    target = pulses + n;
    while (pulses < target) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0;
    strap_div8 = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    summary();
  end

  initial begin
    // R6 / R1: reset default with strap low
    do_reset(1'b0);
    chk(rd_data == 8'h00, "R6 reset strap low", rd_data, 8'h00);
    wait_pulses(3);
    chk(last_gap == 1, "R7 divide-by-1 every cycle", last_gap, 1);

    // R2: non-exact unlock byte leaves window closed
    wr(8'h81);
    chk(rd_data[7] == 1'b0, "R2 0x81 does not unlock", rd_data, 8'h00);
    // R5: guarded write while closed is ignored
    wr(8'h05);
    chk(rd_data == 8'h00, "R5 write while closed ignored", rd_data, 8'h00);

    // R3: window lasts four cycles
    wr(8'h80);
    chk(rd_data == 8'h80, "R3 flag set cycle 1", rd_data, 8'h80);
    repeat (3) @(negedge clk);
    chk(rd_data[7] == 1'b1, "R3 flag still set cycle 4", rd_data, 8'h80);
    @(negedge clk);
    chk(rd_data[7] == 1'b0, "R3 flag cleared after 4", rd_data, 8'h00);
    wr(8'h05);
    chk(rd_data == 8'h00, "R5 write after timeout ignored", rd_data, 8'h00);

    // R4: replayed unlock neither extends nor clears
    wr(8'h80);
    wr(8'h80);
    chk(rd_data[7] == 1'b1, "R4 replay keeps flag", rd_data, 8'h80);
    repeat (2) @(negedge clk);
    chk(rd_data[7] == 1'b1, "R4 flag cycle 4", rd_data, 8'h80);
    @(negedge clk);
    chk(rd_data[7] == 1'b0, "R4 timeout not extended", rd_data, 8'h00);

    // R4 / R5 / R1: bit-7 write in window ignored, then commit with reserved bits
    wr(8'h80);
    wr(8'h8A);
    chk(rd_data == 8'h80, "R4 bit7 write keeps code and flag", rd_data, 8'h80);
    wr(8'h72);
    chk(rd_data == 8'h02, "R1 R5 commit code 2, reserved zero", rd_data, 8'h02);
    wait_pulses(3);
    chk(last_gap == 4, "R7 code 2 period", last_gap, 4);

    // table walk: R5 readback, R7 periods, R8 reserved codes
    for (int i = 0; i < NV; i++) begin
      wr(8'h80);
      wr({4'h0, V_CODE[i]});
      chk(rd_data == {4'h0, V_CODE[i]}, "R5 R8 code readback", rd_data, {4'h0, V_CODE[i]});
      wait_pulses(3);
      chk(last_gap == V_GAP[i], "R7 R8 period", last_gap, V_GAP[i]);
    end

    // R9: change mid-period of 256, old period completes
    wr(8'h80);
    wr(8'h08);
    wait_pulses(2);
    repeat (10) @(negedge clk);
    wr(8'h80);
    wr(8'h00);
    wait_pulses(1);
    chk(last_gap == 256, "R9 running period not shortened", last_gap, 256);
    wait_pulses(1);
    chk(last_gap == 1, "R9 new factor after boundary", last_gap, 1);

    // R6: strap high reset default, then any code writable
    do_reset(1'b1);
    chk(rd_data == 8'h03, "R6 reset strap high", rd_data, 8'h03);
    wait_pulses(3);
    chk(last_gap == 8, "R6 strap divide-by-8", last_gap, 8);
    wr(8'h80);
    wr(8'h00);
    chk(rd_data == 8'h00, "R6 code 0 writable after strap", rd_data, 8'h00);
    wait_pulses(3);
    chk(last_gap == 1, "R6 R7 period back to 1", last_gap, 1);

    summary();
  end
endmodule